// File: doc/BRIEF.md
# Branch Condition Evaluator

A purely combinational decision stage for a processor's branch unit. In conditional mode it takes a 4-bit condition selector and the four arithmetic flags (carry, zero, sign, overflow) and decides whether the branch is taken. In the counted-loop modes it decrements an externally held loop counter. It takes the branch while the decremented count is non-zero, optionally qualified by the zero flag.

The block drives three things: the taken decision, the next counter value to write back, and the next program counter. The next program counter is either the branch target or the sequential fall-through address. The flags are only read and never produced here. Operand comparison, fetch and call/return handling belong to neighbouring logic.

Top module: `branch_cond_eval`

## Requirements
- R1: With `op_kind`=00 (conditional), selector 4'b0000 is always taken and selector 4'b0001 is never taken, whatever the flags.
- R2: In conditional mode, selectors 0010/0011 take on overflow set/clear, 0110/0111 take on zero set/clear (equal/not equal), and 1010/1011 take on sign set/clear.
- R3: In conditional mode, unsigned relations behave as follows. 0100 (below) takes when carry=1. 0101 (above-or-equal) takes when carry=0. 1000 (below-or-equal) takes when carry=1 or zero=1. 1001 (above) takes when carry=0 and zero=0.
- R4: In conditional mode, signed relations behave as follows. 1100 (less) takes when sign≠overflow. 1101 (greater-or-equal) takes when sign=overflow. 1110 (less-or-equal) takes when zero=1 or sign≠overflow. 1111 (greater) takes when zero=0 and sign=overflow.
- R5: In conditional mode, `count_out` equals `count_in`.
- R6: With `op_kind`=01 (plain loop), `count_out` = `count_in`−1 modulo 2^CNT_W. The branch is taken exactly when that value is non-zero, so a count of 0 wraps to all ones and is taken.
- R7: With `op_kind`=10 (loop while zero), taking also requires zero=1. With `op_kind`=11 (loop while not zero), taking also requires zero=0. The count is decremented exactly as in R6.
- R8: `pc_next` equals `pc_target` when `take` is 1 and `pc_seq` otherwise.
- R9: In loop modes, `cond_sel` has no effect on `take`. Carry, sign and overflow also have no effect, and the plain loop ignores the zero flag as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 2 | 00 conditional, 01 loop, 10 loop while zero, 11 loop while not zero |
| cond_sel | input | 4 | Condition code; bit 0 inverts the base condition |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| count_in | input | CNT_W | Current loop counter |
| pc_seq | input | PC_W | Fall-through address |
| pc_target | input | PC_W | Branch target address |
| take | output | 1 | Branch taken |
| count_out | output | CNT_W | Next loop counter value |
| pc_next | output | PC_W | Selected next address |

## Verification
In the qualified loop modes, counter exhaustion and the zero-flag test meet in the same evaluation. Both can veto the branch together, as when a count of 1 arrives with the zero flag opposite to what the mode asks for. The bench sweeps counts 0, 1, 2 and larger against both zero-flag values in every loop mode. It judges `take` as the AND of "decremented count non-zero" and the flag test. The all-ones wrap from a count of 0 must still be taken whenever the flag agrees.

// File: rtl/branch_cond_eval.sv
module branch_cond_eval #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic [1:0]       op_kind,
  input  logic [3:0]       cond_sel,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             flag_s,
  input  logic             flag_o,
  input  logic [CNT_W-1:0] count_in,
  input  logic [PC_W-1:0]  pc_seq,
  input  logic [PC_W-1:0]  pc_target,
  output logic             take,
  output logic [CNT_W-1:0] count_out,
  output logic [PC_W-1:0]  pc_next
);

  localparam logic [1:0] OP_COND    = 2'b00;
  localparam logic [1:0] OP_LOOP    = 2'b01;
  localparam logic [1:0] OP_LOOP_Z  = 2'b10;
  localparam logic [1:0] OP_LOOP_NZ = 2'b11;

  logic             lt_signed;
  logic             base_hit;
  logic             cond_hit;
  logic             is_loop;
  logic [CNT_W-1:0] count_dec;
  logic             loop_live;
  logic             zf_ok;

  assign lt_signed = flag_s ^ flag_o;

  always_comb begin
    case (cond_sel[3:1])
      3'd0:    base_hit = 1'b1;
      3'd1:    base_hit = flag_o;
      3'd2:    base_hit = flag_c;
      3'd3:    base_hit = flag_z;
      3'd4:    base_hit = flag_c | flag_z;
      3'd5:    base_hit = flag_s;
      3'd6:    base_hit = lt_signed;
      default: base_hit = flag_z | lt_signed;
    endcase
  end

  assign cond_hit  = base_hit ^ cond_sel[0];
  assign is_loop   = (op_kind != OP_COND);
  assign count_dec = count_in - CNT_W'(1);
  assign loop_live = |count_dec;

  always_comb begin
    case (op_kind)
      OP_LOOP_Z:  zf_ok = flag_z;
      OP_LOOP_NZ: zf_ok = ~flag_z;
      default:    zf_ok = 1'b1;
    endcase
  end

  assign take      = is_loop ? (loop_live & zf_ok) : cond_hit;
  assign count_out = is_loop ? count_dec : count_in;
  assign pc_next   = take ? pc_target : pc_seq;

  always_comb begin
    a_r1_always: assert (!(op_kind == OP_COND && cond_sel == 4'b0000) || take)
      else $error("R1 always-code not taken");
    a_r5_hold: assert (op_kind != OP_COND || count_out == count_in)
      else $error("R5 counter changed in conditional mode");
    a_r6_step: assert (op_kind == OP_COND || count_out + CNT_W'(1) == count_in)
      else $error("R6 counter not decremented by one");
    a_r6_exhaust: assert (!(op_kind == OP_LOOP && count_in == CNT_W'(1)) || !take)
      else $error("R6 taken on exhausted count");
    a_r7_zf: assert (!((op_kind == OP_LOOP_Z && !flag_z) ||
                       (op_kind == OP_LOOP_NZ && flag_z)) || !take)
      else $error("R7 taken against zero flag");
    a_r8_mux: assert (take ? (pc_next == pc_target) : (pc_next == pc_seq))
      else $error("R8 next address mismatch");
  end

endmodule

// File: tb/branch_cond_eval_test.sv
`timescale 1ns/1ps
module branch_cond_eval_test;
  localparam int PC_W  = 32;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]       op_kind = 2'b00;
  logic [3:0]       cond_sel = 4'b0000;
  logic             flag_c = 0, flag_z = 0, flag_s = 0, flag_o = 0;
  logic [CNT_W-1:0] count_in = '0;
  logic [PC_W-1:0]  pc_seq = '0, pc_target = '0;
  logic             take;
  logic [CNT_W-1:0] count_out;
  logic [PC_W-1:0]  pc_next;

  branch_cond_eval #(.PC_W(PC_W), .CNT_W(CNT_W)) uut (
    .op_kind(op_kind), .cond_sel(cond_sel),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
    .count_in(count_in), .pc_seq(pc_seq), .pc_target(pc_target),
    .take(take), .count_out(count_out), .pc_next(pc_next));

  int total = 0;
  int bad = 0;
  bit driver_done = 0;
  int cycles = 0;

  logic             q_take[$];
  logic [CNT_W-1:0] q_cnt[$];
  logic [PC_W-1:0]  q_pc[$];
  string            q_tag[$];

  function automatic logic model_cond(input logic [3:0] s, input logic c, z, sg, o);
    case (s)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return o;
      4'd3:  return !o;
      4'd4:  return c;
      4'd5:  return !c;
      4'd6:  return z;
      4'd7:  return !z;
      4'd8:  return c || z;
      4'd9:  return !c && !z;
      4'd10: return sg;
      4'd11: return !sg;
      4'd12: return sg != o;
      4'd13: return sg == o;
      4'd14: return z || (sg != o);
      default: return !z && (sg == o);
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] s);
    case (s[3:1])
      3'd0: return "R1";
      3'd2, 3'd4: return "R3";
      3'd6, 3'd7: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic drive(input logic [1:0] k, input logic [3:0] s, input logic [3:0] f,
                       input logic [CNT_W-1:0] cnt, input string tag);
    logic             et;
    logic [CNT_W-1:0] ec;
    @(negedge clk);
    op_kind = k; cond_sel = s;
    {flag_c, flag_z, flag_s, flag_o} = f;
    count_in = cnt;
    pc_seq = 32'h1000_0000 + PC_W'(cycles);
    pc_target = 32'h8000_0000 ^ PC_W'(cnt) ^ PC_W'(s);
    if (k == 2'b00) begin
      et = model_cond(s, f[3], f[2], f[1], f[0]);
      ec = cnt;
    end else begin
      ec = cnt - CNT_W'(1);
      et = (ec != 0);
      if (k == 2'b10) et = et && f[2];
      if (k == 2'b11) et = et && !f[2];
    end
    q_take.push_back(et);
    q_cnt.push_back(ec);
    q_pc.push_back(et ? pc_target : pc_seq);
    q_tag.push_back(tag);
  endtask

  // monitor: scoreboard compare, sampled 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q_tag.size() != 0) begin
        logic             et;
        logic [CNT_W-1:0] ec;
        logic [PC_W-1:0]  ep;
        string            tg;
        et = q_take.pop_front(); ec = q_cnt.pop_front();
        ep = q_pc.pop_front(); tg = q_tag.pop_front();
        total += 3;
        if (take !== et) begin
          bad++; $display("FAIL %s take: got %0b exp %0b (op=%0d sel=%0h)", tg, take, et, op_kind, cond_sel);
        end
        if (count_out !== ec) begin
          bad++; $display("FAIL %s count_out: got %0h exp %0h", (op_kind == 0) ? "R5" : tg, count_out, ec);
        end
        if (pc_next !== ep) begin
          bad++; $display("FAIL R8 pc_next: got %0h exp %0h", pc_next, ep);
        end
      end
    end
  end

  initial begin
    // initial idle state: conditional mode, always-code, zero inputs
    #1;
    total++;
    if (take !== 1'b1 || count_out !== '0 || pc_next !== '0) begin
      bad++; $display("FAIL R1 idle: got take=%0b cnt=%0h pc=%0h exp 1 0 0", take, count_out, pc_next);
    end
    // R1 R2 R3 R4 R5: every code against every flag pattern
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 16; f++)
        drive(2'b00, 4'(s), 4'(f), CNT_W'(16'h0100 + s*16 + f), cond_tag(4'(s)));
    // R6 R7 R9: loop modes, counter exhaustion meets zero-flag test
    for (int k = 1; k < 4; k++)
      for (int ci = 0; ci < 5; ci++)
        for (int f = 0; f < 16; f++) begin
          logic [CNT_W-1:0] cv;
          case (ci)
            0: cv = '0;
            1: cv = CNT_W'(1);
            2: cv = CNT_W'(2);
            3: cv = CNT_W'(37);
            default: cv = '1;
          endcase
          drive(2'(k), 4'((f * 7 + ci) & 15), 4'(f), cv,
                (k == 1) ? ((ci == 0) ? "R6" : "R9") : "R7");
        end
    repeat (3) @(negedge clk);
    driver_done = 1;
  end

  initial begin
    while (!driver_done && cycles < 5000) begin
      @(posedge clk); cycles++;
    end
    if (!driver_done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule